// File: doc/BRIEF.md
# Multi-Locality TPM FIFO Register Front-End

This block is the register-decoding front end of a FIFO-style TPM interface that serves five localities. A host reaches it through a simple synchronous register bus: a 16-bit address, a read strobe, a write strobe and 32-bit write data. Read data comes back registered, one cycle after the strobe. Address bits 15:12 select the locality window, and bits 11:0 select the register inside that window.

The contents the block reports depend on the backend version: unspecified, 1.2 or 2.0. The version is taken from `ver_i` while reset is held and is then frozen. Each locality keeps its own status word, interface-identifier word and command state (idle, ready or executing). Writes to the status register move that command state. In 2.0 mode a status write can also ask the backend to cancel a running command, or to clear the establishment flag. These requests leave the block as single-cycle pulses. The block also holds the number of the locality that last made a command-ready request, or "none".

There is no data stream through this block. The FIFO data register is not decoded, so every pin is a plain control or status signal and has no valid/ready handshake.

Top module: `tpm_fifo_regfront`

## Requirements
- R1: While reset is held and on the cycle after it is released, `rdata_o` is 0, `cancel_o` and `est_rst_o` are low, and `act_loc_o` is 7 (none). Each locality's status word reads back as its family code: 0x04000000 for 2.0 (field bits 27:26 = 1), and 0 for 1.2 or unspecified.
- R2: Reading offset 0x014 (capability) returns 0x30000610 for a 2.0 backend and 0x20000610 for a 1.2 backend. In both cases bit 4 is set, bit 8 is clear, bits 10:9 are 3, and bits 31:28 hold the version field. The read returns 0 when the version is unspecified.
- R3: After reset, offset 0x030 (interface identifier) reads as follows: 0x00002100 for 2.0 (bits 3:0 = 0, bit 8 and bit 13 set), 0xFFFFFFFF for 1.2, and 0 when the version is unspecified.
- R4: A write to offset 0x030 of any valid locality with bit 19 set makes bit 19 set in the interface identifier of all five localities, and it stays set until reset. No other bit of that register can be written.
- R5: Reading offset 0xF00 returns 0x0001 in bits 31:16 and the vendor identifier parameter (default 0x1014) in bits 15:0.
- R6: A status write (offset 0x018) is handled in this priority order:
  - With bit 6 set, the locality enters the ready state. Its status becomes family | 0xC0, and it becomes the active locality.
  - Otherwise, with bit 5 set while the locality is ready, the locality enters execution and its status is cleared to the family code.
  - Otherwise, with bit 1 set, the status becomes family | 0x80.
  - The family field never changes outside reset.
- R7: With a 2.0 backend, a status write with bit 24 set to a locality that is executing raises `cancel_o` for exactly the one cycle after the write. The same write raises nothing in any other state or version.
- R8: With a 2.0 backend, a status write with bit 25 set to locality 3 or 4 raises `est_rst_o` for one cycle, with `est_loc_o` giving the locality. The same write raises nothing for other localities or versions.
- R9: Accesses to locality 5 and above, and to any offset not listed here (including the data FIFO at 0x024), read as 0 and have no effect on any state.
- R10: `rdata_o` carries the addressed value in the cycle after `rd_i` is high, and is 0 in the cycle after `rd_i` is low.
- R11: Changes on `ver_i` after reset is released have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; `ver_i` is sampled while it is low |
| ver_i | input | 2 | Backend version: 0 unspecified, 1 = 1.2, 2 = 2.0 |
| addr_i | input | 16 | Register address; bits 15:12 give the locality |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| act_loc_o | output | 3 | Active locality, 7 when none |
| cancel_o | output | 1 | One-cycle command-cancel request |
| est_rst_o | output | 1 | One-cycle establishment-reset request |
| est_loc_o | output | 3 | Locality that made the establishment-reset request |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least two clock edges.
- `ver_i` is steady during that reset window.
- `rd_i` and `wr_i` are never high together.

With those assumptions, the family field, the frozen version, the sticky lock bit and the ready-before-execution order can all be checked as history properties. The stimulus respects the assumptions: it holds reset for four cycles with the version already applied, and it drives every access as a single strobe on the falling edge. It then runs one table of reads and writes under a 2.0 backend, followed by directed passes for the cancel and establishment gates and for the 1.2 and unspecified resets.

// File: rtl/tpmf_pkg.sv
package tpmf_pkg;
  typedef enum logic [1:0] {VER_NONE = 2'd0, VER_12 = 2'd1, VER_20 = 2'd2} tpm_ver_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READY = 2'd1, ST_EXEC = 2'd2} cmd_state_e;

  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_CAP  = 12'h014;
  localparam logic [OFS_W-1:0] OFS_STS  = 12'h018;
  localparam logic [OFS_W-1:0] OFS_IFID = 12'h030;
  localparam logic [OFS_W-1:0] OFS_DID  = 12'hF00;

  localparam int B_CANCEL = 24;
  localparam int B_ESTRST = 25;
  localparam int B_VALID  = 7;
  localparam int B_CMDRDY = 6;
  localparam int B_GO     = 5;
  localparam int B_RETRY  = 1;
  localparam int B_STDONE = 2;
  localparam int B_LOCK   = 19;
  localparam logic [31:0] STICKY_MASK = (32'h3 << 26) | (32'h1 << B_STDONE);

  function automatic logic [31:0] family_code(tpm_ver_e v);
    return (v == VER_20) ? (32'h1 << 26) : 32'h0;
  endfunction

  function automatic logic [31:0] cap_word(tpm_ver_e v);
    logic [31:0] base;
    base = (32'h1 << 4) | (32'h3 << 9);
    case (v)
      VER_12:  return base | (32'h2 << 28);
      VER_20:  return base | (32'h3 << 28);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ifid_reset(tpm_ver_e v);
    case (v)
      VER_12:  return 32'hFFFF_FFFF;
      VER_20:  return (32'h1 << 8) | (32'h1 << 13);
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/tpmf_decode.sv
module tpmf_decode #(
  parameter int AW      = 16,
  parameter int LOC_LSB = 12,
  parameter int NLOC    = 5,
  parameter int LOC_W   = 3
) (
  input  logic [AW-1:0]    addr,
  output logic [LOC_W-1:0] loc_idx,
  output logic             loc_ok,
  output logic             hit_cap,
  output logic             hit_sts,
  output logic             hit_ifid,
  output logic             hit_did
);
  import tpmf_pkg::*;
  localparam int FLD_W = AW - LOC_LSB;

  logic [FLD_W-1:0] fld;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    fld      = addr[AW-1:LOC_LSB];
    ofs      = addr[OFS_W-1:0];
    loc_ok   = (int'(fld) < NLOC);
    loc_idx  = LOC_W'(fld);
    hit_cap  = loc_ok && (ofs == OFS_CAP);
    hit_sts  = loc_ok && (ofs == OFS_STS);
    hit_ifid = loc_ok && (ofs == OFS_IFID);
    hit_did  = loc_ok && (ofs == OFS_DID);
  end
endmodule

// File: rtl/tpmf_locality.sv
module tpmf_locality (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tpmf_pkg::tpm_ver_e   rst_ver,
  input  logic                 sts_wr,
  input  logic [31:0]          wdata,
  input  logic                 lock_set,
  output logic [31:0]          sts,
  output logic [31:0]          ifid,
  output logic                 in_exec,
  output logic                 claim
);
  import tpmf_pkg::*;

  cmd_state_e  state_q;
  logic [31:0] sts_q;
  logic [31:0] ifid_q;
  logic [31:0] keep;

  always_comb begin
    keep    = sts_q & STICKY_MASK;
    claim   = sts_wr && wdata[B_CMDRDY];
    in_exec = (state_q == ST_EXEC);
    sts     = sts_q;
    ifid    = ifid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= family_code(rst_ver);
      state_q <= ST_IDLE;
      ifid_q  <= ifid_reset(rst_ver);
    end else begin
      if (lock_set) ifid_q[B_LOCK] <= 1'b1;
      if (sts_wr) begin
        if (wdata[B_CMDRDY]) begin
          state_q <= ST_READY;
          sts_q   <= keep | (32'h1 << B_VALID) | (32'h1 << B_CMDRDY);
        end else if (wdata[B_GO] && state_q == ST_READY) begin
          state_q <= ST_EXEC;
          sts_q   <= keep;
        end else if (wdata[B_RETRY]) begin
          sts_q   <= keep | (32'h1 << B_VALID);
        end
      end
    end
  end

  AST_FAMILY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sts_q[27:26])); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_q[B_LOCK] |=> ifid_q[B_LOCK]); // R4
  AST_EXEC_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && $past(state_q) != ST_EXEC) |-> $past(state_q) == ST_READY); // R6
endmodule

// File: rtl/tpm_fifo_regfront.sv
module tpm_fifo_regfront #(
  parameter int          NLOC       = 5,
  parameter int          AW         = 16,
  parameter int          LOC_LSB    = 12,
  parameter logic [15:0] DEV_ID     = 16'h0001,
  parameter logic [15:0] VENDOR_ID  = 16'h1014,
  parameter int          EST_LOC_LO = 3,
  parameter int          EST_LOC_HI = 4,
  localparam int         LOC_W      = $clog2(NLOC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ver_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic [LOC_W-1:0] act_loc_o,
  output logic             cancel_o,
  output logic             est_rst_o,
  output logic [LOC_W-1:0] est_loc_o
);
  import tpmf_pkg::*;
  localparam logic [LOC_W-1:0] LOC_NONE = {LOC_W{1'b1}};

  tpm_ver_e         ver_rst, ver_q;
  logic [LOC_W-1:0] loc_idx;
  logic             loc_ok, hit_cap, hit_sts, hit_ifid, hit_did;
  logic [31:0]      sts_arr  [NLOC];
  logic [31:0]      ifid_arr [NLOC];
  logic [NLOC-1:0]  exec_vec, claim_vec;
  logic             lock_set, sel_exec, v20;
  logic [31:0]      rd_val;

  assign ver_rst = tpm_ver_e'(ver_i);
  assign v20     = (ver_q == VER_20);

  tpmf_decode #(.AW(AW), .LOC_LSB(LOC_LSB), .NLOC(NLOC), .LOC_W(LOC_W)) dec_i (
    .addr(addr_i), .loc_idx(loc_idx), .loc_ok(loc_ok), .hit_cap(hit_cap),
    .hit_sts(hit_sts), .hit_ifid(hit_ifid), .hit_did(hit_did)
  );

  assign lock_set = wr_i && hit_ifid && wdata_i[B_LOCK];

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    tpmf_locality loc_i (
      .clk(clk), .rst_n(rst_n), .rst_ver(ver_rst),
      .sts_wr(wr_i && hit_sts && (int'(loc_idx) == g)),
      .wdata(wdata_i), .lock_set(lock_set),
      .sts(sts_arr[g]), .ifid(ifid_arr[g]),
      .in_exec(exec_vec[g]), .claim(claim_vec[g])
    );
  end

  always_comb begin
    rd_val   = 32'h0;
    sel_exec = 1'b0;
    if (loc_ok && int'(loc_idx) < NLOC) begin
      sel_exec = exec_vec[loc_idx];
      if (hit_cap)  rd_val = cap_word(ver_q);
      if (hit_sts)  rd_val = sts_arr[loc_idx];
      if (hit_ifid) rd_val = ifid_arr[loc_idx];
      if (hit_did)  rd_val = {DEV_ID, VENDOR_ID};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q     <= ver_rst;
      rdata_o   <= 32'h0;
      act_loc_o <= LOC_NONE;
      cancel_o  <= 1'b0;
      est_rst_o <= 1'b0;
      est_loc_o <= '0;
    end else begin
      rdata_o   <= rd_i ? rd_val : 32'h0;
      cancel_o  <= wr_i && hit_sts && v20 && wdata_i[B_CANCEL] && sel_exec;
      est_rst_o <= wr_i && hit_sts && v20 && wdata_i[B_ESTRST] &&
                   (int'(loc_idx) == EST_LOC_LO || int'(loc_idx) == EST_LOC_HI);
      est_loc_o <= loc_idx;
      if (|claim_vec) act_loc_o <= loc_idx;
    end
  end

  AST_CANCEL_V20: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> (ver_q == VER_20 && $past(wr_i))); // R7
  AST_EST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    est_rst_o |-> (int'(est_loc_o) == EST_LOC_LO || int'(est_loc_o) == EST_LOC_HI)); // R8
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_i) |-> rdata_o == 32'h0); // R10
  AST_VER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ver_q)); // R11
endmodule

// File: tb/tpm_fifo_regfront_tb.sv
`timescale 1ns/1ps
module tpm_fifo_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ver_i;
  logic [15:0] addr_i;
  logic        rd_i, wr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [2:0]  act_loc_o, est_loc_o;
  logic        cancel_o, est_rst_o;

  int checks = 0;
  int errors = 0;
  logic        seen_cancel, seen_est;
  logic [2:0]  seen_loc;
  logic [31:0] rval;

  always #4 clk = ~clk;

  tpm_fifo_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .ver_i(ver_i), .addr_i(addr_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .act_loc_o(act_loc_o),
    .cancel_o(cancel_o), .est_rst_o(est_rst_o), .est_loc_o(est_loc_o)
  );

  // {write, addr, wdata, expected read, requirement number}; 2.0 backend
  localparam int NV = 16;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 16'h0014, 32'h0, 32'h3000_0610, 4'd2},  // R2 capability
    {1'b0, 16'h0018, 32'h0, 32'h0400_0000, 4'd1},  // R1 status family
    {1'b0, 16'h0030, 32'h0, 32'h0000_2100, 4'd3},  // R3 interface id
    {1'b0, 16'h0F00, 32'h0, 32'h0001_1014, 4'd5},  // R5 device/vendor
    {1'b0, 16'h5014, 32'h0, 32'h0,         4'd9},  // R9 locality 5
    {1'b0, 16'h0024, 32'h0, 32'h0,         4'd9},  // R9 unmapped offset
    {1'b1, 16'h1018, 32'h0000_0040, 32'h0, 4'd6},  // R6 command ready
    {1'b0, 16'h1018, 32'h0, 32'h0400_00C0, 4'd6},  // R6
    {1'b1, 16'h1018, 32'h0000_0020, 32'h0, 4'd6},  // R6 go
    {1'b0, 16'h1018, 32'h0, 32'h0400_0000, 4'd6},  // R6
    {1'b1, 16'h0018, 32'h0000_0020, 32'h0, 4'd6},  // R6 go while idle
    {1'b0, 16'h0018, 32'h0, 32'h0400_0000, 4'd6},  // R6 unchanged
    {1'b1, 16'h2030, 32'h0008_0000, 32'h0, 4'd4},  // R4 lock
    {1'b0, 16'h4030, 32'h0, 32'h0008_2100, 4'd4},  // R4 broadcast
    {1'b1, 16'h0030, 32'hFFF7_FFFF, 32'h0, 4'd4},  // R4 other bits
    {1'b0, 16'h0030, 32'h0, 32'h0008_2100, 4'd4}   // R4 unchanged
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
    seen_cancel = cancel_o; seen_est = est_rst_o; seen_loc = est_loc_o;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk); addr_i = a; rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic do_reset(input logic [1:0] v);
    @(negedge clk); rst_n = 1'b0; ver_i = v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ver_i = 2'd2; addr_i = '0; rd_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    repeat (4) @(negedge clk);
    chk("R1 rdata in reset", rdata_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 pulses", {30'h0, cancel_o, est_rst_o}, 32'h0);
    chk("R1 active none", 32'(act_loc_o), 32'd7);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) do_write(VEC[i][83:68], VEC[i][67:36]);
      else begin
        do_read(VEC[i][83:68], rval);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), rval, VEC[i][35:4]);
      end
    end

    do_write(16'h5018, 32'h0000_0040);
    chk("R9 loc5 no claim", 32'(act_loc_o), 32'd1);
    chk("R6 active locality", 32'(act_loc_o), 32'd1);

    do_write(16'h1018, 32'h0000_0002);
    do_read(16'h1018, rval);
    chk("R6 retry", rval, 32'h0400_0080);

    do_write(16'h1018, 32'h0100_0000);
    chk("R7 cancel in exec", 32'(seen_cancel), 32'd1);
    @(negedge clk);
    chk("R7 single cycle", 32'(cancel_o), 32'd0);
    do_read(16'h1018, rval);
    chk("R7 status kept", rval, 32'h0400_0080);
    do_write(16'h0018, 32'h0100_0000);
    chk("R7 no cancel idle", 32'(seen_cancel), 32'd0);

    do_write(16'h3018, 32'h0200_0000);
    chk("R8 est loc3", {28'h0, seen_est, seen_loc}, {28'h0, 1'b1, 3'd3});
    do_write(16'h4018, 32'h0200_0000);
    chk("R8 est loc4", {28'h0, seen_est, seen_loc}, {28'h0, 1'b1, 3'd4});
    do_write(16'h2018, 32'h0200_0000);
    chk("R8 no est loc2", 32'(seen_est), 32'd0);

    ver_i = 2'd0;
    do_read(16'h0014, rval);
    chk("R11 version frozen", rval, 32'h3000_0610);
    @(negedge clk);
    chk("R10 idle rdata", rdata_o, 32'h0);

    do_reset(2'd1);
    @(negedge clk);
    chk("R1 active none 1.2", 32'(act_loc_o), 32'd7);
    do_read(16'h0014, rval); chk("R2 cap 1.2", rval, 32'h2000_0610);
    do_read(16'h0018, rval); chk("R1 status 1.2", rval, 32'h0);
    do_read(16'h0030, rval); chk("R3 ifid 1.2", rval, 32'hFFFF_FFFF);
    do_write(16'h3018, 32'h0000_0040);
    do_write(16'h3018, 32'h0000_0020);
    do_write(16'h3018, 32'h0100_0000);
    chk("R7 no cancel 1.2", 32'(seen_cancel), 32'd0);
    do_write(16'h3018, 32'h0200_0000);
    chk("R8 no est 1.2", 32'(seen_est), 32'd0);

    do_reset(2'd0);
    @(negedge clk);
    do_read(16'h0014, rval); chk("R2 cap unspecified", rval, 32'h0);
    do_read(16'h0030, rval); chk("R3 ifid unspecified", rval, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule